// File: doc/BRIEF.md
# Quadrature Encoder Emulator

This block turns a tracking angle word into the signals of an incremental encoder: two square waves in quadrature (A and B) and a once-per-turn index. The encoder has its own resolution, captured from the same two resolution-select lines that set the parallel angle resolution. The capture happens when the emulation-enable pin falls. After that, the parallel resolution may move without changing the A/B rate.

A and B come from the two lowest bits of the angle at the encoder resolution. A is the bit one above the encoder LSB. B is the XOR of that bit and the encoder LSB. At a steady rotation each A/B edge interval is 1/(2^n × revolutions per second). While emulation is disabled, the B pin reports the direction of counting. The index pin is shared with the converter's busy pulse, and the index-enable input chooses which one it carries.

Top module: `enc_emulator`

## Requirements
- R1: While reset is asserted, enc_a, enc_b, index_busy and res_err are 0. After reset the encoder resolution is 16 bits until the first capture.
- R2: The encoder resolution code is taken from res_sel in the clock cycle where emu_n is first sampled low after being sampled high. The code table is 00=10, 01=12, 10=14 and 11=16 bits. A low emu_n that was never seen high does not capture.
- R3: With emulation enabled, enc_a equals angle bit p+1, where p = 16 − n and n is the effective encoder resolution.
- R4: With emulation enabled, enc_b equals angle bit p XOR angle bit p+1.
- R5: With index_en_n low, index_busy is 1 exactly when angle bits 15 down to p are all zero.
- R6: With index_en_n high, index_busy follows busy.
- R7: With emu_n high, enc_a is 0 and enc_b gives the direction of the last nonzero angle change: 1 when the 16-bit modular difference lies in 1..32767, and 0 otherwise. With no change, enc_b holds its value.
- R8: After a capture, a change of res_sel to a code equal to or above the captured one leaves A and B at the captured resolution.
- R9: When the captured code exceeds the current res_sel, res_err is 1 and the effective encoder resolution is clamped to res_sel. Otherwise res_err is 0.
- R10: All outputs are registered. They reflect their inputs one clock after the change and do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| angle | input | 16 | Tracking angle word, natural binary |
| res_sel | input | 2 | Shared resolution-select code |
| emu_n | input | 1 | Active-low emulation enable; its falling edge captures the encoder resolution |
| index_en_n | input | 1 | Low selects index on index_busy, high selects busy |
| busy | input | 1 | Converter busy pulse |
| enc_a | output | 1 | Quadrature channel A |
| enc_b | output | 1 | Quadrature channel B, or direction when emulation is disabled |
| index_busy | output | 1 | Index pulse or busy, as selected |
| res_err | output | 1 | Captured encoder resolution exceeds the parallel resolution |

## Verification
The bench sweeps all four captured codes with angle patterns that set or clear the bits at each candidate position. A design that picks the wrong bit offset, or swaps the XOR for a plain bit, would give the wrong A/B at some resolution. A separate test changes res_sel after a capture to show that A/B stay at the captured rate; a design that reads res_sel live would switch rates. The clamp test moves res_sel below the captured code, and a design without the clamp would emit edges from a finer resolution than the data. The direction test includes a wrap from 0xFFFF to 0x0000, which a design using an unsigned compare would report as a reverse step.

// File: rtl/enc_emulator.sv
module enc_emulator #(
  parameter int W       = 16,
  parameter int MIN_RES = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] angle,
  input  logic [1:0]   res_sel,
  input  logic         emu_n,
  input  logic         index_en_n,
  input  logic         busy,
  output logic         enc_a,
  output logic         enc_b,
  output logic         index_busy,
  output logic         res_err
);
  localparam int SPAN  = W - MIN_RES;
  localparam int POS_W = $clog2(W);

  logic [1:0]       enc_code;
  logic [1:0]       eff_code;
  logic             emu_q;
  logic             dir_q;
  logic             dir_n;
  logic [W-1:0]     prev_angle;
  logic [W-1:0]     delta;
  logic [W-1:0]     shifted;
  logic [POS_W-1:0] lsb_pos;

  assign eff_code = (enc_code > res_sel) ? res_sel : enc_code;
  assign lsb_pos  = POS_W'(SPAN) - POS_W'({eff_code, 1'b0});
  assign shifted  = angle >> lsb_pos;
  assign delta    = angle - prev_angle;
  assign dir_n    = (delta == '0) ? dir_q : ~delta[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_code   <= 2'b11;
      emu_q      <= 1'b0;
      dir_q      <= 1'b1;
      prev_angle <= '0;
      enc_a      <= 1'b0;
      enc_b      <= 1'b0;
      index_busy <= 1'b0;
      res_err    <= 1'b0;
    end else begin
      emu_q      <= emu_n;
      if (emu_q && !emu_n) enc_code <= res_sel;
      prev_angle <= angle;
      dir_q      <= dir_n;
      enc_a      <= !emu_n && shifted[1];
      enc_b      <= emu_n ? dir_n : (shifted[0] ^ shifted[1]);
      index_busy <= index_en_n ? busy : (shifted == '0);
      res_err    <= enc_code > res_sel;
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_q && !emu_n) |=> enc_code == $past(res_sel));

  p_ab_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !emu_n && $past(!emu_n) && angle == $past(angle) &&
     res_sel == $past(res_sel) && enc_code == $past(enc_code))
    |=> $stable({enc_a, enc_b}));

  p_index_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!index_en_n && angle == '0) |=> index_busy);

  p_busy_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    index_en_n |=> index_busy == $past(busy));

  p_err_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_code > res_sel) |=> res_err);
endmodule

// File: tb/enc_emulator_test.sv
module enc_emulator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] angle = '0;
  logic [1:0]  res_sel = 2'b11;
  logic        emu_n = 1'b1;
  logic        index_en_n = 1'b1;
  logic        busy = 1'b0;
  logic        enc_a, enc_b, index_busy, res_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  enc_emulator uut (
    .clk(clk), .rst_n(rst_n), .angle(angle), .res_sel(res_sel),
    .emu_n(emu_n), .index_en_n(index_en_n), .busy(busy),
    .enc_a(enc_a), .enc_b(enc_b), .index_busy(index_busy), .res_err(res_err)
  );

  function automatic int pos(input logic [1:0] code);
    return 6 - 2 * int'(code);
  endfunction
  function automatic logic exp_a(input logic [15:0] ang, input logic [1:0] code);
    return ang[pos(code) + 1];
  endfunction
  function automatic logic exp_b(input logic [15:0] ang, input logic [1:0] code);
    return ang[pos(code)] ^ ang[pos(code) + 1];
  endfunction
  function automatic logic exp_idx(input logic [15:0] ang, input logic [1:0] code);
    return (ang >> pos(code)) == 16'd0;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic capture(input logic [1:0] code);
    emu_n = 1'b1;
    tick();
    res_sel = code;
    emu_n = 1'b0;
    tick();
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; emu_n = 1'b0; res_sel = 2'b11; angle = 16'h0002;
    busy = 1'b1; index_en_n = 1'b1;
    tick(); tick();
    check("R1", "a in reset", enc_a, 1'b0);
    check("R1", "b in reset", enc_b, 1'b0);
    check("R1", "idx in reset", index_busy, 1'b0);
    check("R1", "err in reset", res_err, 1'b0);
    rst_n = 1'b1;
    busy = 1'b0;
    tick();
    check("R1", "default 16-bit a", enc_a, 1'b1);
    check("R1", "default 16-bit b", enc_b, 1'b1);
    check("R1", "default err", res_err, 1'b0);
  endtask

  task automatic t_capture();
    logic [15:0] pats [7] = '{16'h0000, 16'h0040, 16'h0080, 16'h00C0,
                              16'h0010, 16'h0055, 16'hABCD};
    for (int c = 0; c < 4; c++) begin
      capture(2'(c));
      for (int i = 0; i < 7; i++) begin
        angle = pats[i];
        tick();
        check("R2 R3", $sformatf("a code=%0d ang=%h", c, pats[i]), enc_a, exp_a(pats[i], 2'(c)));
        check("R4", $sformatf("b code=%0d ang=%h", c, pats[i]), enc_b, exp_b(pats[i], 2'(c)));
      end
    end
    angle = 16'h0002;
    tick();
    check("R10", "a settled", enc_a, 1'b1);
    angle = 16'h0000;
    #1;
    check("R10", "a before edge", enc_a, 1'b1);
    tick();
    check("R10", "a after edge", enc_a, 1'b0);
  endtask

  task automatic t_independent();
    capture(2'b01);
    res_sel = 2'b11;
    angle = 16'h0010;
    tick();
    check("R8", "a after res change", enc_a, 1'b0);
    check("R8", "b after res change", enc_b, 1'b1);
    angle = 16'h0020;
    tick();
    check("R8", "a 12-bit", enc_a, 1'b1);
    check("R8", "b 12-bit", enc_b, 1'b1);
    check("R8", "no err", res_err, 1'b0);
  endtask

  task automatic t_clamp();
    capture(2'b11);
    res_sel = 2'b00;
    angle = 16'h0080;
    tick();
    check("R9", "err raised", res_err, 1'b1);
    check("R9", "clamped a", enc_a, 1'b1);
    check("R9", "clamped b", enc_b, 1'b1);
    res_sel = 2'b11;
    angle = 16'h0002;
    tick();
    check("R9", "err cleared", res_err, 1'b0);
    check("R9", "unclamped a", enc_a, 1'b1);
  endtask

  task automatic t_index();
    index_en_n = 1'b0;
    capture(2'b10);
    angle = 16'h0003; tick();
    check("R5", "idx low bits only", index_busy, exp_idx(16'h0003, 2'b10));
    angle = 16'h0004; tick();
    check("R5", "idx off at p", index_busy, exp_idx(16'h0004, 2'b10));
    angle = 16'h8000; tick();
    check("R5", "idx off at msb", index_busy, 1'b0);
    busy = 1'b1;
    angle = 16'h0000; tick();
    check("R5", "idx at zero", index_busy, 1'b1);
    busy = 1'b0;
  endtask

  task automatic t_busy();
    index_en_n = 1'b1;
    angle = 16'h0000;
    busy = 1'b1; tick();
    check("R6", "busy high", index_busy, 1'b1);
    busy = 1'b0; tick();
    check("R6", "busy low at zero angle", index_busy, 1'b0);
  endtask

  task automatic t_dir();
    emu_n = 1'b1;
    angle = 16'h1000; tick();
    angle = 16'h1001; tick();
    check("R7", "up dir", enc_b, 1'b1);
    check("R7", "a low when disabled", enc_a, 1'b0);
    angle = 16'h1000; tick();
    check("R7", "down dir", enc_b, 1'b0);
    tick();
    check("R7", "hold dir", enc_b, 1'b0);
    angle = 16'hFFFF; tick();
    check("R7", "large drop", enc_b, 1'b0);
    angle = 16'h0000; tick();
    check("R7", "wrap up", enc_b, 1'b1);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_independent();
    t_clamp();
    t_index();
    t_busy();
    t_dir();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule